// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block performs the multi-cycle memory work that a processor needs in three cases: taking a hardware interrupt, entering a system call, and returning from either. It keeps a register of pending interrupt vectors. At an instruction boundary it picks the lowest-numbered pending vector and reads that vector's word from the interrupt table. A system call request reads the word for its call number from the system call table instead. If the entry is enabled and the handler address is word aligned, the block pushes the saved state onto a stack through a single 32-bit word memory port. It then reports, in one commit cycle, the new program counter, status word and stack pointer.

The surrounding core supplies the current program counter, status word, R15 and supervisor stack pointer. It applies the committed values and holds its fetch stage while `busy` is high. On a return the block pops the program counter and the status word. When the restored status shows user mode, it also pops the previous R15. A disabled system call entry, a misaligned handler or return address, and a return attempted outside supervisor mode are each reported as a one-cycle error pulse. The core's own error logic deals with them.

Top module: `trap_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `commit` and all three error outputs are low.
- R2: Vector n of the interrupt table is read as one word at address 0x00000 + 4n. Call n of the system call table is read at 0x00100 + 4n. In a table word, bit 31 is the enable and bits 19:0 are the handler address.
- R3: A system call entry, and an interrupt entry while status bit 16 (the mode bit) is 0, first sets the stack pointer to the zero-extended supervisor stack pointer. It then pushes the old R15 to that pointer minus 4.
- R4: Every entry pushes the status word and then the program counter, zero-extended to 32 bits. Each push writes at the stack pointer minus 4, and the pointer moves down by 4. An interrupt taken while the mode bit is 1 starts from the current R15.
- R5: A completed entry raises `commit` for one cycle. `pc_new` is the handler address, `ms_new` is the saved status word with bit 16 set, and `r15_new` is the final stack pointer.
- R6: A disabled interrupt entry produces only the table read: no push, no commit and no error. Its pending bit is gone afterwards.
- R7: A disabled system call entry produces the table read and an `err_disabled` pulse, with no push and no commit.
- R8: A handler address whose bits 1:0 are not zero produces an `err_align` pulse after the table read, with no push and no commit.
- R9: A return reads the program counter at R15 and then the status word at R15+4. If the restored bit 16 is 0, it also reads a new R15 at R15+8. The commit then carries the popped program counter, the popped status word, and either the popped R15 or the pointer after the pops.
- R10: A return requested while the current mode bit is 0 raises `err_priv` with no memory access.
- R11: A popped program counter whose bits 1:0 are not zero raises `err_align`, and no commit follows.
- R12: Among the pending vectors, the lowest-numbered one is serviced first. Its pending bit clears when its entry starts, so it is serviced only once per raise.
- R13: A pending interrupt is accepted only when `at_boundary` is high and the block is idle. A system call or return request in the same cycle takes precedence, and the interrupt waits for a later boundary.
- R14: At most one memory request is outstanding. Its address, write enable and write data stay unchanged until `mem_ready` completes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raise | input | 64 | One-cycle pulses that mark interrupt vectors pending |
| at_boundary | input | 1 | The fetch stage is between instructions |
| scl_req | input | 1 | System call request pulse |
| scl_vec | input | 6 | System call number |
| ret_req | input | 1 | Return-from-trap request pulse |
| cur_pc | input | 20 | Address of the next instruction |
| cur_ms | input | 32 | Current status word |
| cur_r15 | input | 32 | Current stack register |
| ssp | input | 20 | Supervisor stack pointer |
| busy | output | 1 | A flow is in progress; the fetch stage stalls |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| commit | output | 1 | New state is valid for one cycle |
| pc_new | output | 20 | Program counter to load |
| ms_new | output | 32 | Status word to load |
| r15_new | output | 32 | Stack register to load |
| err_disabled | output | 1 | Disabled system call entry |
| err_align | output | 1 | Misaligned handler or return address |
| err_priv | output | 1 | Return attempted with the mode bit clear |

## Verification
The functions that can collide are an instruction's request (a system call or return) and the acceptance of a pending interrupt at the same instruction boundary. The bench raises a vector first. It then drives `scl_req` and `at_boundary` together in one cycle. The scoreboard requires the complete system call flow (table read at the call table, pushes, commit) before any access to the interrupt table. After the return, a later boundary must produce exactly the deferred interrupt's table read. A further boundary with nothing pending must produce no memory traffic at all.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TBL,
    S_PSH_SP,
    S_PSH_MS,
    S_PSH_PC,
    S_POP_PC,
    S_POP_MS,
    S_POP_SP,
    S_DONE
  } tstate_e;

endpackage

// File: rtl/trap_pending.sv
module trap_pending #(
  parameter int unsigned NVEC = 64,
  parameter int unsigned VW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] raise,
  input  logic            accept,
  input  logic [VW-1:0]   acc_vec,
  output logic            any,
  output logic [VW-1:0]   vec
);

  logic [NVEC-1:0] pend_q;
  logic [NVEC-1:0] pend_d;
  logic [NVEC-1:0] clr;
  logic            pend_en;

  // one clear line per vector
  genvar g;
  generate
    for (g = 0; g < NVEC; g++) begin : g_clr
      assign clr[g] = accept && (acc_vec == VW'(g));
    end
  endgenerate

  assign pend_d  = (pend_q & ~clr) | raise;
  assign pend_en = accept || (|raise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    vec = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (pend_q[i]) vec = VW'(i);
    end
  end

  assign any = |pend_q;

endmodule

// File: rtl/trap_mport.sv
module trap_mport
  import trap_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned XW = 32,
  parameter int unsigned VW = 6,
  parameter logic [AW-1:0] IVT_BASE = 20'h00000,
  parameter logic [AW-1:0] SCT_BASE = 20'h00100
) (
  input  tstate_e        st,
  input  logic           is_scl,
  input  logic [VW-1:0]  vec,
  input  logic [XW-1:0]  sp,
  input  logic [XW-1:0]  r15s,
  input  logic [XW-1:0]  mss,
  input  logic [AW-1:0]  pcs,
  output logic           req,
  output logic           we,
  output logic [AW-1:0]  addr,
  output logic [XW-1:0]  wdata
);

  logic [XW-1:0] sp_dn;
  logic [AW-1:0] tbl_off;
  logic          unused_hi;

  assign sp_dn     = sp - XW'(4);
  assign tbl_off   = AW'({vec, 2'b00});
  assign unused_hi = ^{sp_dn[XW-1:AW], sp[XW-1:AW]};

  always_comb begin
    req   = 1'b0;
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    case (st)
      S_TBL: begin
        req  = 1'b1;
        addr = (is_scl ? SCT_BASE : IVT_BASE) + tbl_off;
      end
      S_PSH_SP: begin
        req   = 1'b1;
        we    = 1'b1;
        addr  = sp_dn[AW-1:0];
        wdata = r15s;
      end
      S_PSH_MS: begin
        req   = 1'b1;
        we    = 1'b1;
        addr  = sp_dn[AW-1:0];
        wdata = mss;
      end
      S_PSH_PC: begin
        req   = 1'b1;
        we    = 1'b1;
        addr  = sp_dn[AW-1:0];
        wdata = {{(XW-AW){1'b0}}, pcs};
      end
      S_POP_PC, S_POP_MS, S_POP_SP: begin
        req  = 1'b1;
        addr = sp[AW-1:0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
  import trap_pkg::*;
#(
  parameter int unsigned AW     = 20,
  parameter int unsigned XW     = 32,
  parameter int unsigned VW     = 6,
  parameter int unsigned MB     = 16,
  parameter int unsigned EB     = 31
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           at_boundary,
  input  logic           irq_any,
  input  logic [VW-1:0]  irq_vec,
  output logic           irq_accept,
  input  logic           scl_req,
  input  logic [VW-1:0]  scl_vec,
  input  logic           ret_req,
  input  logic [AW-1:0]  cur_pc,
  input  logic [XW-1:0]  cur_ms,
  input  logic [XW-1:0]  cur_r15,
  input  logic [AW-1:0]  ssp,
  input  logic           mem_ready,
  input  logic [XW-1:0]  mem_rdata,
  output tstate_e        st,
  output logic           is_scl,
  output logic [VW-1:0]  vec,
  output logic [XW-1:0]  sp,
  output logic [XW-1:0]  r15s,
  output logic [XW-1:0]  mss,
  output logic [AW-1:0]  pcs,
  output logic [AW-1:0]  pco,
  output logic           edis,
  output logic           ealn,
  output logic           eprv
);

  tstate_e       st_q, st_d;
  logic          scl_q, scl_d;
  logic [VW-1:0] vec_q, vec_d;
  logic [XW-1:0] sp_q, sp_d;
  logic [XW-1:0] r15s_q, r15s_d;
  logic [XW-1:0] mss_q, mss_d;
  logic [AW-1:0] pcs_q, pcs_d;
  logic [AW-1:0] pco_q, pco_d;
  logic          edis_q, edis_d;
  logic          ealn_q, ealn_d;
  logic          eprv_q, eprv_d;
  logic          upd;

  localparam logic [XW-1:0] MODE_SET = XW'(1) << MB;

  always_comb begin
    st_d       = st_q;
    scl_d      = scl_q;
    vec_d      = vec_q;
    sp_d       = sp_q;
    r15s_d     = r15s_q;
    mss_d      = mss_q;
    pcs_d      = pcs_q;
    pco_d      = pco_q;
    edis_d     = 1'b0;
    ealn_d     = 1'b0;
    eprv_d     = 1'b0;
    irq_accept = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (scl_req) begin
          st_d   = S_TBL;
          scl_d  = 1'b1;
          vec_d  = scl_vec;
          r15s_d = cur_r15;
          mss_d  = cur_ms;
          pcs_d  = cur_pc;
        end else if (ret_req) begin
          if (cur_ms[MB]) begin
            st_d = S_POP_PC;
            sp_d = cur_r15;
          end else begin
            eprv_d = 1'b1;
          end
        end else if (at_boundary && irq_any) begin
          irq_accept = 1'b1;
          st_d   = S_TBL;
          scl_d  = 1'b0;
          vec_d  = irq_vec;
          r15s_d = cur_r15;
          mss_d  = cur_ms;
          pcs_d  = cur_pc;
        end
      end
      S_TBL: begin
        if (mem_ready) begin
          if (!mem_rdata[EB]) begin
            edis_d = scl_q;
            st_d   = S_IDLE;
          end else if (mem_rdata[1:0] != 2'b00) begin
            ealn_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            pco_d = mem_rdata[AW-1:0];
            if (scl_q || !mss_q[MB]) begin
              sp_d = {{(XW-AW){1'b0}}, ssp};
              st_d = S_PSH_SP;
            end else begin
              sp_d = r15s_q;
              st_d = S_PSH_MS;
            end
          end
        end
      end
      S_PSH_SP: begin
        if (mem_ready) begin
          sp_d = sp_q - XW'(4);
          st_d = S_PSH_MS;
        end
      end
      S_PSH_MS: begin
        if (mem_ready) begin
          sp_d = sp_q - XW'(4);
          st_d = S_PSH_PC;
        end
      end
      S_PSH_PC: begin
        if (mem_ready) begin
          sp_d  = sp_q - XW'(4);
          mss_d = mss_q | MODE_SET;
          st_d  = S_DONE;
        end
      end
      S_POP_PC: begin
        if (mem_ready) begin
          if (mem_rdata[1:0] != 2'b00) begin
            ealn_d = 1'b1;
            st_d   = S_IDLE;
          end else begin
            pco_d = mem_rdata[AW-1:0];
            sp_d  = sp_q + XW'(4);
            st_d  = S_POP_MS;
          end
        end
      end
      S_POP_MS: begin
        if (mem_ready) begin
          mss_d = mem_rdata;
          sp_d  = sp_q + XW'(4);
          st_d  = mem_rdata[MB] ? S_DONE : S_POP_SP;
        end
      end
      S_POP_SP: begin
        if (mem_ready) begin
          sp_d = mem_rdata;
          st_d = S_DONE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign upd = (st_q != S_IDLE) || scl_req || ret_req || irq_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      edis_q <= 1'b0;
      ealn_q <= 1'b0;
      eprv_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      edis_q <= edis_d;
      ealn_q <= ealn_d;
      eprv_q <= eprv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b0;
      vec_q  <= '0;
      sp_q   <= '0;
      r15s_q <= '0;
      mss_q  <= '0;
      pcs_q  <= '0;
      pco_q  <= '0;
    end else if (upd) begin
      scl_q  <= scl_d;
      vec_q  <= vec_d;
      sp_q   <= sp_d;
      r15s_q <= r15s_d;
      mss_q  <= mss_d;
      pcs_q  <= pcs_d;
      pco_q  <= pco_d;
    end
  end

  assign st     = st_q;
  assign is_scl = scl_q;
  assign vec    = vec_q;
  assign sp     = sp_q;
  assign r15s   = r15s_q;
  assign mss    = mss_q;
  assign pcs    = pcs_q;
  assign pco    = pco_q;
  assign edis   = edis_q;
  assign ealn   = ealn_q;
  assign eprv   = eprv_q;

endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int unsigned   NVEC     = 64,
  parameter int unsigned   AW       = 20,
  parameter int unsigned   XW       = 32,
  parameter int unsigned   MB       = 16,
  parameter int unsigned   EB       = 31,
  parameter logic [19:0]   IVT_BASE = 20'h00000,
  parameter logic [19:0]   SCT_BASE = 20'h00100,
  localparam int unsigned  VW       = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] irq_raise,
  input  logic            at_boundary,
  input  logic            scl_req,
  input  logic [VW-1:0]   scl_vec,
  input  logic            ret_req,
  input  logic [AW-1:0]   cur_pc,
  input  logic [XW-1:0]   cur_ms,
  input  logic [XW-1:0]   cur_r15,
  input  logic [AW-1:0]   ssp,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [XW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [XW-1:0]   mem_rdata,
  output logic            commit,
  output logic [AW-1:0]   pc_new,
  output logic [XW-1:0]   ms_new,
  output logic [XW-1:0]   r15_new,
  output logic            err_disabled,
  output logic            err_align,
  output logic            err_priv
);

  tstate_e       st;
  logic          irq_any;
  logic [VW-1:0] irq_vec;
  logic          irq_accept;
  logic          is_scl;
  logic [VW-1:0] vec;
  logic [XW-1:0] sp;
  logic [XW-1:0] r15s;
  logic [XW-1:0] mss;
  logic [AW-1:0] pcs;
  logic [AW-1:0] pco;

  trap_pending #(.NVEC(NVEC), .VW(VW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise   (irq_raise),
    .accept  (irq_accept),
    .acc_vec (irq_vec),
    .any     (irq_any),
    .vec     (irq_vec)
  );

  trap_fsm #(.AW(AW), .XW(XW), .VW(VW), .MB(MB), .EB(EB)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .at_boundary (at_boundary),
    .irq_any     (irq_any),
    .irq_vec     (irq_vec),
    .irq_accept  (irq_accept),
    .scl_req     (scl_req),
    .scl_vec     (scl_vec),
    .ret_req     (ret_req),
    .cur_pc      (cur_pc),
    .cur_ms      (cur_ms),
    .cur_r15     (cur_r15),
    .ssp         (ssp),
    .mem_ready   (mem_ready),
    .mem_rdata   (mem_rdata),
    .st          (st),
    .is_scl      (is_scl),
    .vec         (vec),
    .sp          (sp),
    .r15s        (r15s),
    .mss         (mss),
    .pcs         (pcs),
    .pco         (pco),
    .edis        (err_disabled),
    .ealn        (err_align),
    .eprv        (err_priv)
  );

  trap_mport #(
    .AW(AW), .XW(XW), .VW(VW),
    .IVT_BASE(AW'(IVT_BASE)), .SCT_BASE(AW'(SCT_BASE))
  ) u_mport (
    .st     (st),
    .is_scl (is_scl),
    .vec    (vec),
    .sp     (sp),
    .r15s   (r15s),
    .mss    (mss),
    .pcs    (pcs),
    .req    (mem_req),
    .we     (mem_we),
    .addr   (mem_addr),
    .wdata  (mem_wdata)
  );

  assign busy    = (st != S_IDLE);
  assign commit  = (st == S_DONE);
  assign pc_new  = pco;
  assign ms_new  = mss;
  assign r15_new = sp;

endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
  parameter int unsigned AW = 20,
  parameter int unsigned XW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_req,
  input logic          ret_req,
  input logic          at_boundary,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [XW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          commit,
  input logic [AW-1:0] pc_new,
  input logic          err_disabled,
  input logic          err_align,
  input logic          err_priv
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R14

  AST_REQ_IN_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R14

  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(scl_req || ret_req || at_boundary)); // R13

  AST_COMMIT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> pc_new[1:0] == 2'b00); // R8

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit, err_disabled, err_align, err_priv})); // R7

  AST_PRIV_NO_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    err_priv |-> !busy && !mem_req); // R10

endmodule

bind trap_seq trap_seq_chk #(.AW(AW), .XW(XW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_req      (scl_req),
  .ret_req      (ret_req),
  .at_boundary  (at_boundary),
  .busy         (busy),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ready    (mem_ready),
  .commit       (commit),
  .pc_new       (pc_new),
  .err_disabled (err_disabled),
  .err_align    (err_align),
  .err_priv     (err_priv)
);

// File: tb/sim_trap_seq.sv
`timescale 1ns/1ps
module sim_trap_seq;

  logic        clk;
  logic        rst_n;
  logic [63:0] irq_raise;
  logic        at_boundary;
  logic        scl_req;
  logic [5:0]  scl_vec;
  logic        ret_req;
  logic [19:0] m_pc;
  logic [31:0] m_ms;
  logic [31:0] m_r15;
  logic [19:0] m_ssp;
  logic        busy, mem_req, mem_we, mem_ready, commit;
  logic [19:0] mem_addr, pc_new;
  logic [31:0] mem_wdata, mem_rdata, ms_new, r15_new;
  logic        err_disabled, err_align, err_priv;

  int checks = 0;
  int errors = 0;

  trap_seq u0 (
    .clk(clk), .rst_n(rst_n), .irq_raise(irq_raise), .at_boundary(at_boundary),
    .scl_req(scl_req), .scl_vec(scl_vec), .ret_req(ret_req),
    .cur_pc(m_pc), .cur_ms(m_ms), .cur_r15(m_r15), .ssp(m_ssp),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .commit(commit), .pc_new(pc_new), .ms_new(ms_new), .r15_new(r15_new),
    .err_disabled(err_disabled), .err_align(err_align), .err_priv(err_priv)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- memory model with varying latency ----------------
  logic [31:0] mem [logic [19:0]];
  logic [31:0] shd [logic [19:0]];
  int          lat;
  logic [1:0]  pat;

  function automatic logic [31:0] mem_rd(input logic [19:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] shd_rd(input logic [19:0] a);
    return shd.exists(a) ? shd[a] : 32'h0;
  endfunction

  assign mem_ready = mem_req && (lat == 0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= 0;
      pat <= 2'd0;
    end else if (mem_req) begin
      if (lat == 0) begin
        lat <= int'(pat);
        pat <= pat + 2'd1;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready && mem_we) mem[mem_addr] = mem_wdata;
  end

  always @(negedge clk) mem_rdata <= mem_rd(mem_addr);

  // ---------------- scoreboard ----------------
  typedef struct {
    int          kind;   // 0 read, 1 write, 2 commit, 3 err_dis, 4 err_aln, 5 err_prv
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    string       tag;
  } ev_t;
  ev_t q[$];

  task automatic expect_ev(input int k, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] c, input string tag);
    ev_t e;
    e.kind = k; e.a = a; e.b = b; e.c = c; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic got(input int k, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    ev_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R6/R12 unexpected event kind=%0d a=%h b=%h c=%h expected none", k, a, b, c);
    end else begin
      e = q.pop_front();
      if (e.kind != k || e.a != a || ((k == 1 || k == 2) && e.b != b) || (k == 2 && e.c != c)) begin
        errors++;
        $display("FAIL %s actual kind=%0d a=%h b=%h c=%h expected kind=%0d a=%h b=%h c=%h",
                 e.tag, k, a, b, c, e.kind, e.a, e.b, e.c);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ready) got(mem_we ? 1 : 0, {12'h0, mem_addr}, mem_wdata, 32'h0);
      if (commit)       got(2, {12'h0, pc_new}, ms_new, r15_new);
      if (err_disabled) got(3, 32'h0, 32'h0, 32'h0);
      if (err_align)    got(4, 32'h0, 32'h0, 32'h0);
      if (err_priv)     got(5, 32'h0, 32'h0, 32'h0);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          n_ok;
  logic [19:0] n_pc;
  logic [31:0] n_ms, n_r15;

  task automatic push_exp(inout logic [31:0] sp, input logic [31:0] v, input string tag);
    sp = sp - 32'd4;
    shd[sp[19:0]] = v;
    expect_ev(1, {12'h0, sp[19:0]}, v, 32'h0, tag);
  endtask

  task automatic exp_entry(input bit scl, input int n, input string rtag);
    logic [19:0] ta;
    logic [31:0] ent, sp;
    ta = (scl ? 20'h00100 : 20'h00000) + 20'(4 * n);
    ent = mem_rd(ta);
    n_ok = 1'b0;
    expect_ev(0, {12'h0, ta}, 32'h0, 32'h0, rtag);
    if (!ent[31]) begin
      if (scl) expect_ev(3, 0, 0, 0, "R7");
    end else if (ent[1:0] != 2'b00) begin
      expect_ev(4, 0, 0, 0, "R8");
    end else begin
      if (scl || !m_ms[16]) begin
        sp = {12'h0, m_ssp};
        push_exp(sp, m_r15, "R3");
      end else begin
        sp = m_r15;
      end
      push_exp(sp, m_ms, "R4");
      push_exp(sp, {12'h0, m_pc}, "R4");
      n_ok = 1'b1; n_pc = ent[19:0]; n_ms = m_ms | 32'h0001_0000; n_r15 = sp;
      expect_ev(2, {12'h0, n_pc}, n_ms, n_r15, "R5");
    end
  endtask

  task automatic exp_ret();
    logic [31:0] sp, v, ms;
    n_ok = 1'b0;
    if (!m_ms[16]) begin
      expect_ev(5, 0, 0, 0, "R10");
    end else begin
      sp = m_r15;
      expect_ev(0, {12'h0, sp[19:0]}, 0, 0, "R9");
      v = shd_rd(sp[19:0]);
      if (v[1:0] != 2'b00) begin
        expect_ev(4, 0, 0, 0, "R11");
      end else begin
        sp = sp + 32'd4;
        expect_ev(0, {12'h0, sp[19:0]}, 0, 0, "R9");
        ms = shd_rd(sp[19:0]);
        sp = sp + 32'd4;
        if (!ms[16]) begin
          expect_ev(0, {12'h0, sp[19:0]}, 0, 0, "R9");
          sp = shd_rd(sp[19:0]);
        end
        n_ok = 1'b1; n_pc = v[19:0]; n_ms = ms; n_r15 = sp;
        expect_ev(2, {12'h0, n_pc}, n_ms, n_r15, "R9");
      end
    end
  endtask

  // ---------------- drivers ----------------
  task automatic finish_flow();
    while (busy) @(negedge clk);
    @(negedge clk);
    if (n_ok) begin
      m_pc = n_pc; m_ms = n_ms; m_r15 = n_r15;
    end
  endtask

  task automatic raise(input logic [63:0] m);
    @(negedge clk); irq_raise = m;
    @(negedge clk); irq_raise = '0;
  endtask

  task automatic boundary_flow();
    @(negedge clk); at_boundary = 1'b1;
    @(negedge clk); at_boundary = 1'b0;
    finish_flow();
  endtask

  task automatic scl_flow(input int n);
    exp_entry(1'b1, n, "R2");
    @(negedge clk); scl_req = 1'b1; scl_vec = 6'(n);
    @(negedge clk); scl_req = 1'b0;
    finish_flow();
  endtask

  task automatic ret_flow();
    exp_ret();
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    finish_flow();
  endtask

  task automatic tbl(input logic [19:0] base, input int n, input logic [31:0] v);
    mem[base + 20'(4 * n)] = v;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_raise = '0; at_boundary = 1'b0; scl_req = 1'b0; scl_vec = '0; ret_req = 1'b0;
    m_pc = 20'h00200; m_ms = 32'h0001_0001; m_r15 = 32'h0000_6000; m_ssp = 20'h07F00;
    tbl(20'h00000, 2,  32'h8000_0400);
    tbl(20'h00000, 5,  32'h8000_0480);
    tbl(20'h00000, 9,  32'h0000_0500);
    tbl(20'h00000, 11, 32'h8000_0402);
    tbl(20'h00100, 3,  32'h8000_0600);
    tbl(20'h00100, 7,  32'h0000_0700);
    tbl(20'h00100, 63, 32'h8000_0604);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !mem_req && !commit, "R1 busy/req/commit", {busy, mem_req, commit}, 0);
    check(!err_disabled && !err_align && !err_priv, "R1 errors", {err_disabled, err_align, err_priv}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12: two vectors pending, the lower one goes first; supervisor mode, no switch (R4)
    raise(64'h24);
    repeat (3) @(negedge clk);
    check(!busy, "R13 no entry without boundary", busy, 0);
    exp_entry(1'b0, 2, "R12");
    boundary_flow();
    ret_flow();                                 // R9 restored supervisor, no R15 pop

    // R3: user-mode interrupt switches stacks
    m_ms = 32'h0000_0004; m_r15 = 32'h000A_0000;
    exp_entry(1'b0, 5, "R12");
    boundary_flow();
    ret_flow();                                 // R9 restored user, R15 popped
    ret_flow();                                 // R10 privilege violation from user mode

    // R13: system call and boundary with pending interrupt in the same cycle
    raise(64'h200);
    exp_entry(1'b1, 3, "R13");
    @(negedge clk); scl_req = 1'b1; scl_vec = 6'd3; at_boundary = 1'b1;
    @(negedge clk); scl_req = 1'b0; at_boundary = 1'b0;
    finish_flow();
    ret_flow();
    // R6: deferred interrupt 9 is disabled: table read only
    exp_entry(1'b0, 9, "R6");
    boundary_flow();
    check(!busy && !commit, "R6 no flow after disabled entry", {busy, commit}, 0);
    // R12: pending bit cleared, a further boundary does nothing
    boundary_flow();
    repeat (4) @(negedge clk);
    check(q.size() == 0 && !busy, "R12 nothing left pending", q.size(), 0);

    scl_flow(7);                                // R7 disabled system call
    raise(64'h800);
    exp_entry(1'b0, 11, "R8");                  // R8 misaligned handler
    boundary_flow();

    // R11: misaligned return address
    m_ms = 32'h0001_0000; m_r15 = 32'h0000_6100;
    mem[20'h06100] = 32'h0000_0403; shd[20'h06100] = 32'h0000_0403;
    ret_flow();

    // R3: system call from supervisor mode still switches stacks
    scl_flow(63);
    ret_flow();

    repeat (6) @(negedge clk);
    // R14: every expected transaction arrived in order under varying latency
    check(q.size() == 0, "R14 all expected events seen", q.size(), 0);
    summary();
    $finish;
  end

endmodule